// File: doc/BRIEF.md
# Word Memory with Mapped I/O Ports

This block is the main store of a small 16-bit processor. It holds 4096 words of 16 bits behind a 12-bit word address, with separate write-data and read-data buses and separate read and write enables. The eight lowest addresses are not RAM. They select I/O registers: a switch input, an LED register, a digit-select register, a segment register, a general output port and a general input port. Two of the eight I/O addresses are unused.

Above the I/O window the map is plain RAM in two regions. Words 0x008 to 0x07F form the data region and words 0x080 to 0xFFF form the program region. Both regions behave the same way in hardware. A decoder sorts each address into one of three regions (`RGN_IO`, `RGN_DATA`, `RGN_PROG`). A write is sent either to the port selected by the address or to the RAM array. A read registers either the zero-extended port value or the RAM word, and the result appears on the next cycle.

Top module: `wmio_mem`

## Requirements
- R1: While `rst_n` is low, `rdata`, `led_out`, `dig_sel`, `seg_out` and `port_out` are all zero.
- R2: A word written with `wr_en` high to an address of 0x008 or above is returned by a later read of that address.
- R3: `rdata` changes only on the rising edge where `rd_en` is high, so read data is valid one cycle after the request. With `rd_en` low, `rdata` holds its value, even while writes take place.
- R4: A read of address 0x000 returns the 8-bit switch input zero-extended to 16 bits, sampled at that edge.
- R5: A write to address 0x001 loads `wdata[7:0]` into `led_out` and ignores the upper bits. A read of 0x001 returns that value zero-extended.
- R6: A write to 0x002 loads `wdata[3:0]` into `dig_sel`. A write to 0x003 loads `wdata[7:0]` into `seg_out`. Reads of these addresses return the stored values zero-extended.
- R7: A write to 0x004 loads `wdata[3:0]` into `port_out`. A read of 0x005 returns the 4-bit `port_in` zero-extended. A write to 0x005 changes no output.
- R8: Addresses 0x006 and 0x007 read as zero, and writes to them change no output.
- R9: A write to one I/O address leaves every other port register unchanged.
- R10: When a read and a write hit the same RAM address in one cycle, the read returns the old word and the new word is stored.
- R11: The region boundaries 0x008, 0x07F, 0x080 and 0xFFF all behave as RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request; data appears next cycle |
| wr_en | input | 1 | Write request |
| addr | input | 12 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| sw_in | input | 8 | Switch input, read at 0x000 |
| led_out | output | 8 | LED register, at 0x001 |
| dig_sel | output | 4 | Digit-select register, at 0x002 |
| seg_out | output | 8 | Segment register, at 0x003 |
| port_out | output | 4 | General output port, at 0x004 |
| port_in | input | 4 | General input port, read at 0x005 |

## Verification
The bench targets the edges of the I/O window and the region boundaries:
- Address 0x008 must reach RAM and must not alias a port.
- Addresses 0x07F and 0x080 must both store words. A decoder off by one would lose the word or route it to an I/O register.
- Writes to the input-port address and to the two unused addresses must leave every output port unchanged. A design with loose decoding would corrupt an output port.
- Wide write data must be truncated, and port reads must be zero-extended. A design that gets this wrong leaks upper bits into `rdata` or the port registers.
- A same-cycle read and write to one RAM word must return the old word. A design that forwards the new word would break a read-modify-write sequence.
- `rdata` must stay fixed while `rd_en` is low. A design that reads combinationally would let it follow the address.

// File: rtl/wmio_pkg.sv
package wmio_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 16;
    localparam int IO_SPAN  = 8;
    localparam int IDX_W    = $clog2(IO_SPAN);
    localparam int DATA_TOP = 'h07F;
    localparam int SW_W     = 8;
    localparam int LED_W    = 8;
    localparam int DIG_W    = 4;
    localparam int SEG_W    = 8;
    localparam int PO_W     = 4;
    localparam int PI_W     = 4;
    localparam int PORT_DW  = 8;

    typedef enum logic [1:0] {
        RGN_IO   = 2'd0,
        RGN_DATA = 2'd1,
        RGN_PROG = 2'd2
    } region_e;

    typedef enum logic [IDX_W-1:0] {
        IO_SW   = 3'd0,
        IO_LED  = 3'd1,
        IO_DIG  = 3'd2,
        IO_SEG  = 3'd3,
        IO_POUT = 3'd4,
        IO_PIN  = 3'd5,
        IO_NC6  = 3'd6,
        IO_NC7  = 3'd7
    } io_idx_e;
endpackage

// File: rtl/wmio_decode.sv
module wmio_decode
    import wmio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              is_io,
    output io_idx_e           io_idx
);
    region_e region;

    always_comb begin
        if (addr < ADDR_W'(IO_SPAN))
            region = RGN_IO;
        else if (addr <= ADDR_W'(DATA_TOP))
            region = RGN_DATA;
        else
            region = RGN_PROG;
    end

    assign is_io  = (region == RGN_IO);
    assign io_idx = io_idx_e'(addr[IDX_W-1:0]);
endmodule

// File: rtl/wmio_ports.sv
module wmio_ports
    import wmio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_we,
    input  io_idx_e            io_idx,
    input  logic [PORT_DW-1:0] wbits,
    input  logic [SW_W-1:0]    sw_in,
    input  logic [PI_W-1:0]    port_in,
    output logic [LED_W-1:0]   led_q,
    output logic [DIG_W-1:0]   dig_q,
    output logic [SEG_W-1:0]   seg_q,
    output logic [PO_W-1:0]    pout_q,
    output logic [DATA_W-1:0]  io_rd_val
);
    logic we_led, we_dig, we_seg, we_pout;

    always_comb begin
        we_led  = 1'b0;
        we_dig  = 1'b0;
        we_seg  = 1'b0;
        we_pout = 1'b0;
        if (io_we) begin
            unique case (io_idx)
                IO_LED:  we_led  = 1'b1;
                IO_DIG:  we_dig  = 1'b1;
                IO_SEG:  we_seg  = 1'b1;
                IO_POUT: we_pout = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q  <= '0;
            dig_q  <= '0;
            seg_q  <= '0;
            pout_q <= '0;
        end else begin
            if (we_led)  led_q  <= wbits[LED_W-1:0];
            if (we_dig)  dig_q  <= wbits[DIG_W-1:0];
            if (we_seg)  seg_q  <= wbits[SEG_W-1:0];
            if (we_pout) pout_q <= wbits[PO_W-1:0];
        end
    end

    always_comb begin
        unique case (io_idx)
            IO_SW:   io_rd_val = {{(DATA_W-SW_W){1'b0}},  sw_in};
            IO_LED:  io_rd_val = {{(DATA_W-LED_W){1'b0}}, led_q};
            IO_DIG:  io_rd_val = {{(DATA_W-DIG_W){1'b0}}, dig_q};
            IO_SEG:  io_rd_val = {{(DATA_W-SEG_W){1'b0}}, seg_q};
            IO_POUT: io_rd_val = {{(DATA_W-PO_W){1'b0}},  pout_q};
            IO_PIN:  io_rd_val = {{(DATA_W-PI_W){1'b0}},  port_in};
            default: io_rd_val = '0;
        endcase
    end

    // R9
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_we && io_idx == IO_LED) |=> $stable(led_q));
    // R5
    led_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_idx == IO_LED) |=> led_q == $past(wbits[LED_W-1:0]));
    // R7
    pout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_we && io_idx == IO_POUT) |=> $stable(pout_q));
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_led, we_dig, we_seg, we_pout}));
endmodule

// File: rtl/wmio_ram.sv
module wmio_ram
    import wmio_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rq
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rq <= mem[addr];
    end
endmodule

// File: rtl/wmio_mem.sv
module wmio_mem
    import wmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic [7:0]        sw_in,
    output logic [7:0]        led_out,
    output logic [3:0]        dig_sel,
    output logic [7:0]        seg_out,
    output logic [3:0]        port_out,
    input  logic [3:0]        port_in
);
    logic              is_io;
    io_idx_e           io_idx;
    logic [DATA_W-1:0] io_rd_val;
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] io_q;
    logic              sel_io_q;

    wmio_decode u_dec (
        .addr   (addr),
        .is_io  (is_io),
        .io_idx (io_idx)
    );

    wmio_ports u_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_we     (wr_en && is_io),
        .io_idx    (io_idx),
        .wbits     (wdata[PORT_DW-1:0]),
        .sw_in     (sw_in),
        .port_in   (port_in),
        .led_q     (led_out),
        .dig_q     (dig_sel),
        .seg_q     (seg_out),
        .pout_q    (port_out),
        .io_rd_val (io_rd_val)
    );

    wmio_ram u_ram (
        .clk   (clk),
        .we    (wr_en && !is_io),
        .re    (rd_en && !is_io),
        .addr  (addr),
        .wdata (wdata),
        .rq    (ram_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_io_q <= 1'b1;
            io_q     <= '0;
        end else if (rd_en) begin
            sel_io_q <= is_io;
            if (is_io) io_q <= io_rd_val;
        end
    end

    assign rdata = sel_io_q ? io_q : ram_q;

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R4
    sw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 12'h000) |=> rdata == {8'h00, $past(sw_in)});
    // R8
    nc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 12'h006 || addr == 12'h007)) |=> rdata == 16'h0000);
    // R7
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 12'h005) |=> rdata == {12'h000, $past(port_in)});
endmodule

// File: tb/tb_wmio_mem.sv
`timescale 1ns/1ps
module tb_wmio_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  sw_in = '0;
    logic [7:0]  led_out;
    logic [3:0]  dig_sel;
    logic [7:0]  seg_out;
    logic [3:0]  port_out;
    logic [3:0]  port_in = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    wmio_mem dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .sw_in(sw_in),
        .led_out(led_out), .dig_sel(dig_sel), .seg_out(seg_out),
        .port_out(port_out), .port_in(port_in)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: note a read at the edge, compare at the following falling edge
    always @(posedge clk) rd_seen <= rd_en && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 16'hDEAD, 16'h0000);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ports(input string tag, input logic [7:0] l, input logic [3:0] d,
                         input logic [7:0] s, input logic [3:0] p);
        check({tag, " led"}, {8'h0, led_out}, {8'h0, l});
        check({tag, " dig"}, {12'h0, dig_sel}, {12'h0, d});
        check({tag, " seg"}, {8'h0, seg_out}, {8'h0, s});
        check({tag, " pout"}, {12'h0, port_out}, {12'h0, p});
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata", rdata, 16'h0000);
        ports("R1", 8'h00, 4'h0, 8'h00, 4'h0);
        rst_n = 1'b1;

        wr(12'h010, 16'h1234);
        rd(12'h010, 16'h1234, "R2 0x010");
        wr(12'h008, 16'h0BEE);
        wr(12'h07F, 16'hA5A5);
        wr(12'h080, 16'h5A5A);
        wr(12'hFFF, 16'hFFFF);
        rd(12'h008, 16'h0BEE, "R11 0x008");
        rd(12'h07F, 16'hA5A5, "R11 0x07F");
        rd(12'h080, 16'h5A5A, "R11 0x080");
        rd(12'hFFF, 16'hFFFF, "R11 0xFFF");

        sw_in = 8'h3C;
        rd(12'h000, 16'h003C, "R4 sw 3C");
        sw_in = 8'hC3;
        rd(12'h000, 16'h00C3, "R4 sw C3");

        wr(12'h001, 16'hFFAB);
        ports("R5", 8'hAB, 4'h0, 8'h00, 4'h0);
        rd(12'h001, 16'h00AB, "R5 led read");

        wr(12'h002, 16'h123F);
        wr(12'h003, 16'hFFE7);
        ports("R6 R9", 8'hAB, 4'hF, 8'hE7, 4'h0);
        rd(12'h002, 16'h000F, "R6 dig read");
        rd(12'h003, 16'h00E7, "R6 seg read");

        wr(12'h004, 16'hFFF9);
        port_in = 4'h6;
        ports("R7 pout", 8'hAB, 4'hF, 8'hE7, 4'h9);
        rd(12'h005, 16'h0006, "R7 pin");
        wr(12'h005, 16'hFFFF);
        ports("R7 pin write", 8'hAB, 4'hF, 8'hE7, 4'h9);
        rd(12'h005, 16'h0006, "R7 pin after write");
        rd(12'h004, 16'h0009, "R7 pout read");

        wr(12'h006, 16'hFFFF);
        wr(12'h007, 16'hFFFF);
        ports("R8 nc write", 8'hAB, 4'hF, 8'hE7, 4'h9);
        rd(12'h006, 16'h0000, "R8 0x006");
        rd(12'h007, 16'h0000, "R8 0x007");

        // R3: rdata holds while reads are idle, even across writes
        rd(12'h010, 16'h1234, "R3 setup");
        wr(12'h010, 16'h7777);
        wr(12'h001, 16'h0011);
        repeat (3) @(negedge clk);
        check("R3 hold", rdata, 16'h1234);
        rd(12'h010, 16'h7777, "R3 new read");

        // R10: same-cycle read and write of one RAM word
        wr(12'h020, 16'h1111);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 12'h020; wdata = 16'h2222;
        exp_q.push_back(16'h1111); tag_q.push_back("R10 old word");
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        rd(12'h020, 16'h2222, "R10 new word");

        repeat (3) @(negedge clk);
        check("scoreboard drained", 16'(exp_q.size()), 16'h0000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule